// File: doc/BRIEF.md
# Virtual Name Translation Cache

This block keeps a small hardware table that turns a global virtual object name into a local segment descriptor. A segment descriptor is a base address and a length. Software puts a name and its descriptor into the table with an enter request. A translate request looks the name up. On a hit it writes the descriptor into one of several address registers, which sit outside the block and are reached through a write port. On a miss it raises a fault, and a software handler then resolves the name.

The table is two-way set-associative. The set is picked by the low bits of the name, and each set records which of its two ways was used least recently. An enter request takes one cycle. A translate request runs a fixed three-stage lookup, and the block shows busy while the lookup runs.

A separate bounds unit checks indexed accesses against a descriptor. It gives either the effective address or a bounds fault. The bounds fault has its own code, distinct from the miss code.

Top module: `vname_xlat_cache`

## Requirements
- R1: After reset, busy, the address-register write strobe, the translate fault and the access-done flag are all low, and the table is empty, so the first translate misses.
- R2: A translate that hits pulses `ar_we_o` for one cycle. In that cycle `ar_sel_o` equals the register index given with the request, and `ar_base_o`/`ar_len_o` equal the descriptor most recently entered for that name.
- R3: A translate accepted at clock edge t (valid high, busy low) holds `busy_o` high for the three cycles after edges t, t+1 and t+2. Its result appears in the cycle after edge t+3, and in that cycle busy is low.
- R4: Any request (enter or translate) presented while `busy_o` is high is ignored. An enter request never raises busy.
- R5: A translate that misses pulses `xl_fault_o` for one cycle, with `xl_code_o` = 2'b01 and no register write. A translate hit reports `xl_code_o` = 2'b00.
- R6: Entering a name that is already present overwrites that entry's descriptor in place. The other way of the set is left untouched.
- R7: Two names that map to the same set are held at the same time, one per way.
- R8: Entering a new name into a full set replaces the least recently used way. Both enter and translate-hit make a way the most recently used.
- R9: An access check presented with `acc_valid_i` reports one cycle later with `acc_done_o`. If the index is at or beyond the length, `acc_fault_o` is high and `acc_code_o` = 2'b10. Otherwise `acc_code_o` = 2'b00 and `acc_addr_o` = base + index.
- R10: The set index is the low log2(SETS) bits of the name (bits [2:0] by default). Filling one set has no effect on names held in another set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid_i | input | 1 | Request present |
| req_enter_i | input | 1 | 1 = enter, 0 = translate |
| req_name_i | input | NAME_W | Virtual object name |
| req_base_i | input | BASE_W | Descriptor base (enter) |
| req_len_i | input | LEN_W | Descriptor length (enter) |
| req_reg_i | input | REG_W | Target address register (translate) |
| busy_o | output | 1 | Translate in progress; requests ignored |
| ar_we_o | output | 1 | Address-register write strobe (hit) |
| ar_sel_o | output | REG_W | Address register selected |
| ar_base_o | output | BASE_W | Descriptor base written |
| ar_len_o | output | LEN_W | Descriptor length written |
| xl_fault_o | output | 1 | Translation miss fault |
| xl_code_o | output | 2 | Translate fault code |
| acc_valid_i | input | 1 | Access check request |
| acc_base_i | input | BASE_W | Segment base for the access |
| acc_len_i | input | LEN_W | Segment length for the access |
| acc_idx_i | input | LEN_W | Index into the segment |
| acc_done_o | output | 1 | Access check result valid |
| acc_fault_o | output | 1 | Bounds violation |
| acc_code_o | output | 2 | Access fault code |
| acc_addr_o | output | BASE_W | Effective address when in bounds |

## Verification
The assertions check the following on every cycle:
- the three-cycle busy window and the result that follows it;
- that an enter request leaves busy low;
- that a hit and a miss never occur together, and that a miss always carries the miss code;
- the one-cycle latency of the bounds check, and that its fault matches the index-versus-length comparison.

Table contents can only be shown by the bench's scenarios. These cover descriptor values returned on a hit, in-place overwrite, least-recently-used eviction after a recency update, isolation between sets, and an enter that is dropped because it arrived during a lookup.

// File: rtl/vnx_pkg.sv
package vnx_pkg;
    typedef enum logic [1:0] {
        FLT_NONE   = 2'b00,
        FLT_MISS   = 2'b01,
        FLT_BOUNDS = 2'b10
    } flt_e;

    localparam int WAYS = 2;
endpackage

// File: rtl/xlat_way_pick.sv
// Chooses the way used by a lookup or an insertion within one set.
module xlat_way_pick (
    input  logic [1:0] vld_i,
    input  logic [1:0] match_i,
    input  logic       lru_i,
    output logic       hit_o,
    output logic       way_o
);
    always_comb begin
        hit_o = |match_i;
        if (match_i[1])      way_o = 1'b1;
        else if (match_i[0]) way_o = 1'b0;
        else if (!vld_i[0])  way_o = 1'b0;
        else if (!vld_i[1])  way_o = 1'b1;
        else                 way_o = lru_i;
    end
endmodule

// File: rtl/seg_bounds_chk.sv
// Registered segment-length check and effective address generation.
module seg_bounds_chk #(
    parameter int BASE_W = 16,
    parameter int LEN_W  = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              valid_i,
    input  logic [BASE_W-1:0] base_i,
    input  logic [LEN_W-1:0]  len_i,
    input  logic [LEN_W-1:0]  idx_i,
    output logic              done_o,
    output logic              fault_o,
    output logic [1:0]        code_o,
    output logic [BASE_W-1:0] addr_o
);
    import vnx_pkg::*;

    typedef struct packed {
        logic              done;
        logic              fault;
        flt_e              code;
        logic [BASE_W-1:0] addr;
    } bst_t;

    bst_t bs_d, bs_q;

    always_comb begin
        bs_d       = bs_q;
        bs_d.done  = valid_i;
        bs_d.fault = valid_i && (idx_i >= len_i);
        bs_d.code  = bs_d.fault ? FLT_BOUNDS : FLT_NONE;
        bs_d.addr  = (valid_i && !bs_d.fault) ? base_i + BASE_W'(idx_i) : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) bs_q <= '0;
        else        bs_q <= bs_d;
    end

    assign done_o  = bs_q.done;
    assign fault_o = bs_q.fault;
    assign code_o  = bs_q.code;
    assign addr_o  = bs_q.addr;
endmodule

// File: rtl/vname_xlat_cache.sv
module vname_xlat_cache #(
    parameter int NAME_W   = 16,
    parameter int BASE_W   = 16,
    parameter int LEN_W    = 12,
    parameter int SETS     = 8,
    parameter int NUM_REGS = 4,
    localparam int REG_W   = $clog2(NUM_REGS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid_i,
    input  logic              req_enter_i,
    input  logic [NAME_W-1:0] req_name_i,
    input  logic [BASE_W-1:0] req_base_i,
    input  logic [LEN_W-1:0]  req_len_i,
    input  logic [REG_W-1:0]  req_reg_i,
    output logic              busy_o,
    output logic              ar_we_o,
    output logic [REG_W-1:0]  ar_sel_o,
    output logic [BASE_W-1:0] ar_base_o,
    output logic [LEN_W-1:0]  ar_len_o,
    output logic              xl_fault_o,
    output logic [1:0]        xl_code_o,
    input  logic              acc_valid_i,
    input  logic [BASE_W-1:0] acc_base_i,
    input  logic [LEN_W-1:0]  acc_len_i,
    input  logic [LEN_W-1:0]  acc_idx_i,
    output logic              acc_done_o,
    output logic              acc_fault_o,
    output logic [1:0]        acc_code_o,
    output logic [BASE_W-1:0] acc_addr_o
);
    import vnx_pkg::*;

    localparam int SET_W = $clog2(SETS);
    localparam int TAG_W = NAME_W - SET_W;

    // Lookup stage encoding: 0 idle, 1 tag compare, 2 descriptor select, 3 result.
    typedef struct packed {
        logic [1:0]                               stg;
        logic [NAME_W-1:0]                        name;
        logic [REG_W-1:0]                         sel;
        logic                                     hit;
        logic                                     way;
        logic [BASE_W-1:0]                        base;
        logic [LEN_W-1:0]                         len;
        logic                                     ar_we;
        logic                                     xl_fault;
        logic [SETS-1:0]                          lru;
        logic [SETS-1:0][WAYS-1:0]                vld;
        logic [SETS-1:0][WAYS-1:0][TAG_W-1:0]     tag;
        logic [SETS-1:0][WAYS-1:0][BASE_W-1:0]    dbase;
        logic [SETS-1:0][WAYS-1:0][LEN_W-1:0]     dlen;
    } st_t;

    st_t st_d, st_q;

    logic              busy;
    logic              accept;
    logic [NAME_W-1:0] look_name;
    logic [SET_W-1:0]  look_set;
    logic [TAG_W-1:0]  look_tag;
    logic [WAYS-1:0]   match;
    logic              pick_hit;
    logic              pick_way;

    assign busy      = (st_q.stg != 2'd0);
    assign accept    = req_valid_i && !busy;
    assign look_name = busy ? st_q.name : req_name_i;
    assign look_set  = look_name[SET_W-1:0];
    assign look_tag  = look_name[NAME_W-1:SET_W];

    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        assign match[w] = st_q.vld[look_set][w] && (st_q.tag[look_set][w] == look_tag);
    end

    xlat_way_pick pick_i (
        .vld_i   (st_q.vld[look_set]),
        .match_i (match),
        .lru_i   (st_q.lru[look_set]),
        .hit_o   (pick_hit),
        .way_o   (pick_way)
    );

    always_comb begin
        st_d          = st_q;
        st_d.ar_we    = 1'b0;
        st_d.xl_fault = 1'b0;
        unique case (st_q.stg)
            2'd0: begin
                if (accept && req_enter_i) begin
                    st_d.vld[look_set][pick_way]   = 1'b1;
                    st_d.tag[look_set][pick_way]   = look_tag;
                    st_d.dbase[look_set][pick_way] = req_base_i;
                    st_d.dlen[look_set][pick_way]  = req_len_i;
                    st_d.lru[look_set]             = ~pick_way;
                end else if (accept) begin
                    st_d.stg  = 2'd1;
                    st_d.name = req_name_i;
                    st_d.sel  = req_reg_i;
                end
            end
            2'd1: begin
                st_d.hit = pick_hit;
                st_d.way = pick_way;
                st_d.stg = 2'd2;
            end
            2'd2: begin
                st_d.base = st_q.hit ? st_q.dbase[look_set][st_q.way] : '0;
                st_d.len  = st_q.hit ? st_q.dlen[look_set][st_q.way]  : '0;
                st_d.stg  = 2'd3;
            end
            2'd3: begin
                st_d.ar_we    = st_q.hit;
                st_d.xl_fault = !st_q.hit;
                if (st_q.hit) st_d.lru[look_set] = ~st_q.way;
                st_d.stg = 2'd0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy_o     = busy;
    assign ar_we_o    = st_q.ar_we;
    assign ar_sel_o   = st_q.sel;
    assign ar_base_o  = st_q.base;
    assign ar_len_o   = st_q.len;
    assign xl_fault_o = st_q.xl_fault;
    assign xl_code_o  = st_q.xl_fault ? FLT_MISS : FLT_NONE;

    seg_bounds_chk #(.BASE_W(BASE_W), .LEN_W(LEN_W)) bounds_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .valid_i (acc_valid_i),
        .base_i  (acc_base_i),
        .len_i   (acc_len_i),
        .idx_i   (acc_idx_i),
        .done_o  (acc_done_o),
        .fault_o (acc_fault_o),
        .code_o  (acc_code_o),
        .addr_o  (acc_addr_o)
    );
endmodule

// File: rtl/vname_xlat_cache_chk.sv
module vname_xlat_cache_chk #(
    parameter int LEN_W = 12
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid_i,
    input logic             req_enter_i,
    input logic             busy_o,
    input logic             ar_we_o,
    input logic             xl_fault_o,
    input logic [1:0]       xl_code_o,
    input logic             acc_valid_i,
    input logic [LEN_W-1:0] acc_len_i,
    input logic [LEN_W-1:0] acc_idx_i,
    input logic             acc_done_o,
    input logic             acc_fault_o,
    input logic [1:0]       acc_code_o
);
    // R3
    xlat_busy_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_i && !req_enter_i && !busy_o) |=>
            busy_o ##1 busy_o ##1 busy_o ##1 (!busy_o && (ar_we_o || xl_fault_o)));

    // R3
    result_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ar_we_o || xl_fault_o) |-> ($past(busy_o) && !busy_o));

    // R4
    enter_no_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_i && req_enter_i && !busy_o) |=> !busy_o);

    // R5
    hit_miss_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(ar_we_o && xl_fault_o));

    // R5
    miss_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        xl_fault_o |-> (xl_code_o == 2'b01));

    // R9
    acc_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid_i |=> acc_done_o);

    // R9
    acc_done_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc_done_o |-> $past(acc_valid_i));

    // R9
    acc_fault_rule_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc_done_o |-> (acc_fault_o == $past(acc_idx_i >= acc_len_i)));

    // R9
    acc_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc_done_o |-> (acc_code_o == (acc_fault_o ? 2'b10 : 2'b00)));
endmodule

bind vname_xlat_cache vname_xlat_cache_chk #(.LEN_W(LEN_W)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid_i (req_valid_i),
    .req_enter_i (req_enter_i),
    .busy_o      (busy_o),
    .ar_we_o     (ar_we_o),
    .xl_fault_o  (xl_fault_o),
    .xl_code_o   (xl_code_o),
    .acc_valid_i (acc_valid_i),
    .acc_len_i   (acc_len_i),
    .acc_idx_i   (acc_idx_i),
    .acc_done_o  (acc_done_o),
    .acc_fault_o (acc_fault_o),
    .acc_code_o  (acc_code_o)
);

// File: tb/vname_xlat_cache_tb_top.sv
module vname_xlat_cache_tb_top;
    localparam int CLK_PERIOD = 10;

    // Access-check vectors: {base[16], len[12], idx[12], exp_fault, exp_addr[16]}
    localparam logic [56:0] ACC_VEC [6] = '{
        {16'h1000, 12'h010, 12'h000, 1'b0, 16'h1000},
        {16'h1000, 12'h010, 12'h00F, 1'b0, 16'h100F},
        {16'h1000, 12'h010, 12'h010, 1'b1, 16'h0000},
        {16'h2000, 12'h000, 12'h000, 1'b1, 16'h0000},
        {16'hFFF0, 12'hFFF, 12'h00F, 1'b0, 16'hFFFF},
        {16'h0100, 12'h800, 12'hFFF, 1'b1, 16'h0000}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_enter = 1'b0;
    logic [15:0] req_name = '0, req_base = '0;
    logic [11:0] req_len = '0;
    logic [1:0]  req_reg = '0;
    logic        busy, ar_we, xl_fault;
    logic [1:0]  ar_sel, xl_code;
    logic [15:0] ar_base;
    logic [11:0] ar_len;
    logic        acc_valid = 1'b0;
    logic [15:0] acc_base = '0;
    logic [11:0] acc_len = '0, acc_idx = '0;
    logic        acc_done, acc_fault;
    logic [1:0]  acc_code;
    logic [15:0] acc_addr;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    vname_xlat_cache dut_i (
        .clk(clk), .rst_n(rst_n),
        .req_valid_i(req_valid), .req_enter_i(req_enter), .req_name_i(req_name),
        .req_base_i(req_base), .req_len_i(req_len), .req_reg_i(req_reg),
        .busy_o(busy), .ar_we_o(ar_we), .ar_sel_o(ar_sel), .ar_base_o(ar_base),
        .ar_len_o(ar_len), .xl_fault_o(xl_fault), .xl_code_o(xl_code),
        .acc_valid_i(acc_valid), .acc_base_i(acc_base), .acc_len_i(acc_len),
        .acc_idx_i(acc_idx), .acc_done_o(acc_done), .acc_fault_o(acc_fault),
        .acc_code_o(acc_code), .acc_addr_o(acc_addr)
    );

    task automatic check(input string rq, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
        end
    endtask

    task automatic do_enter(input logic [15:0] nm, input logic [15:0] b, input logic [11:0] l);
        @(negedge clk);
        req_valid = 1'b1; req_enter = 1'b1; req_name = nm; req_base = b; req_len = l;
        @(negedge clk);
        req_valid = 1'b0; req_enter = 1'b0;
    endtask

    task automatic check_result(input string rq, input logic [1:0] rs, input logic exp_hit,
                                input logic [15:0] eb, input logic [11:0] el);
        check("R3", "busy low at result", 32'(busy), 32'd0);
        check(rq, "register write", 32'(ar_we), 32'(exp_hit));
        check("R5", "miss fault", 32'(xl_fault), 32'(!exp_hit));
        if (exp_hit) begin
            check("R2", "selected register", 32'(ar_sel), 32'(rs));
            check(rq, "descriptor base", 32'(ar_base), 32'(eb));
            check(rq, "descriptor length", 32'(ar_len), 32'(el));
            check("R5", "hit code", 32'(xl_code), 32'd0);
        end else begin
            check("R5", "miss code", 32'(xl_code), 32'd1);
        end
    endtask

    // Presented at a negedge, accepted at the next posedge (t); busy for the
    // cycles after t, t+1, t+2; result in the cycle after t+3.
    task automatic do_xlat(input logic [15:0] nm, input logic [1:0] rs, input logic exp_hit,
                           input logic [15:0] eb, input logic [11:0] el, input string rq);
        @(negedge clk);
        req_valid = 1'b1; req_enter = 1'b0; req_name = nm; req_reg = rs;
        @(negedge clk);
        req_valid = 1'b0;
        for (int i = 0; i < 3; i++) begin
            if (i > 0) @(negedge clk);
            check("R3", "busy during lookup", 32'(busy), 32'd1);
            check("R3", "no early result", 32'({ar_we, xl_fault}), 32'd0);
        end
        @(negedge clk);
        check_result(rq, rs, exp_hit, eb, el);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1", "busy after reset", 32'(busy), 32'd0);
        check("R1", "write strobe after reset", 32'(ar_we), 32'd0);
        check("R1", "fault after reset", 32'(xl_fault), 32'd0);
        check("R1", "access done after reset", 32'(acc_done), 32'd0);
        do_xlat(16'h0000, 2'd0, 1'b0, 16'h0, 12'h0, "R1");

        // R2 basic enter and hit
        do_enter(16'h0010, 16'h1234, 12'h040);
        do_xlat(16'h0010, 2'd2, 1'b1, 16'h1234, 12'h040, "R2");

        // R7 second name in same set (set 0)
        do_enter(16'h0020, 16'h2000, 12'h100);
        do_xlat(16'h0020, 2'd3, 1'b1, 16'h2000, 12'h100, "R7");
        do_xlat(16'h0010, 2'd1, 1'b1, 16'h1234, 12'h040, "R7");

        // R8 full set: 0x0020 is least recent and gets replaced
        do_enter(16'h0030, 16'h3000, 12'h008);
        do_xlat(16'h0020, 2'd0, 1'b0, 16'h0, 12'h0, "R8");
        do_xlat(16'h0030, 2'd0, 1'b1, 16'h3000, 12'h008, "R8");
        do_xlat(16'h0010, 2'd1, 1'b1, 16'h1234, 12'h040, "R8");

        // R6 overwrite in place
        do_enter(16'h0010, 16'h0ABC, 12'h111);
        do_xlat(16'h0010, 2'd2, 1'b1, 16'h0ABC, 12'h111, "R6");
        do_xlat(16'h0030, 2'd3, 1'b1, 16'h3000, 12'h008, "R6");

        // R4 enter presented during lookup is dropped
        @(negedge clk);
        req_valid = 1'b1; req_enter = 1'b0; req_name = 16'h0010; req_reg = 2'd1;
        @(negedge clk);
        req_enter = 1'b1; req_name = 16'h0005; req_base = 16'h5555; req_len = 12'h055;
        check("R4", "busy while enter held", 32'(busy), 32'd1);
        @(negedge clk);
        @(negedge clk);
        check("R4", "busy still high", 32'(busy), 32'd1);
        @(negedge clk);
        req_valid = 1'b0; req_enter = 1'b0;
        check_result("R4", 2'd1, 1'b1, 16'h0ABC, 12'h111);
        do_xlat(16'h0005, 2'd0, 1'b0, 16'h0, 12'h0, "R4");

        // R10 set isolation: fill set 2, set 3 unaffected
        do_enter(16'h0003, 16'h3333, 12'h010);
        do_enter(16'h0002, 16'h0200, 12'h020);
        do_enter(16'h000A, 16'h0A00, 12'h0A0);
        do_enter(16'h0012, 16'h1200, 12'h120);
        do_xlat(16'h0002, 2'd0, 1'b0, 16'h0, 12'h0, "R10");
        do_xlat(16'h0003, 2'd1, 1'b1, 16'h3333, 12'h010, "R10");
        do_xlat(16'h0012, 2'd2, 1'b1, 16'h1200, 12'h120, "R10");
        do_xlat(16'h000A, 2'd3, 1'b1, 16'h0A00, 12'h0A0, "R10");

        // R9 bounds vectors
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            acc_valid = 1'b1;
            acc_base  = ACC_VEC[k][56:41];
            acc_len   = ACC_VEC[k][40:29];
            acc_idx   = ACC_VEC[k][28:17];
            @(negedge clk);
            acc_valid = 1'b0;
            check("R9", "access done", 32'(acc_done), 32'd1);
            check("R9", "bounds fault", 32'(acc_fault), 32'(ACC_VEC[k][16]));
            check("R9", "access code", 32'(acc_code), ACC_VEC[k][16] ? 32'd2 : 32'd0);
            if (!ACC_VEC[k][16])
                check("R9", "effective address", 32'(acc_addr), 32'(ACC_VEC[k][15:0]));
        end
        @(negedge clk);
        check("R9", "done drops", 32'(acc_done), 32'd0);

        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule